// File: doc/BRIEF.md
# Synchronous Serial Engine

This block is a full-duplex serial port that can act as bus master or as slave. In master mode it makes the serial clock and an active-low select from the module clock. In slave mode it follows a clock and a select that come from outside. Both modes share one shift engine. It handles all four clock polarity and phase combinations and frame widths from 4 to 16 bits, and the most significant bit goes out first.

Software writes transmit words into an 8-entry FIFO and takes received words from a second 8-entry FIFO. Before each access it checks a not-full flag and a not-empty flag. The serial rate comes from a two-stage divider: an even prescaler followed by an 8-bit rate counter. In slave mode a control bit can keep the data output undriven, so that several slaves can listen on a shared line while only one of them answers.

Top module: `sync_serial_port`

## Requirements
- R1: In master mode one serial clock period lasts `ctl_pre * (1 + ctl_frame[15:8])` module clocks. `ctl_pre` must be even and at least 2, and the rate field runs from 0 to 255.
- R2: The frame width is `ctl_frame[3:0] + 1` bits, from 4 to 16. Bits of a transmit word above that width have no effect. A received word is right-justified and its upper bits read as zero.
- R3: `ctl_frame[6]` is the clock polarity and `ctl_frame[7]` is the clock phase. The mode number is {polarity, phase}, so mode 0 is 0/0, mode 1 is 0/1, mode 2 is 1/0 and mode 3 is 1/1. The idle clock level equals the polarity. Phase 0 samples on the leading edge and changes data on the trailing edge. Phase 1 changes data on the leading edge and samples on the trailing edge. `ctl_frame[5:4]` must be 00.
- R4: The most significant bit of the frame is shifted first. It is already on `sdo` before the first clock edge of a frame.
- R5: In master mode `cs_n_o` goes low while frames run. It stays low between back-to-back frames while transmit data is waiting, and goes high when the transmit FIFO runs empty.
- R6: The transmit FIFO holds 8 words. `tx_not_full` is low when the FIFO is full, and a write made while it is full is dropped.
- R7: The receive FIFO holds 8 words. `rx_not_empty` shows that it has data, `rd_data` presents the oldest word, and `rd_en` removes that word.
- R8: With `ctl_slave`=1, the inputs `sck_i`, `cs_n_i` and `sdi` are synchronised before use, so the module clock must run at least 12 times the bit rate. While selected, the slave shifts the head of the transmit FIFO out on `sdo` (zeros if the FIFO is empty), receives from `sdi`, and holds `sdo_en` high.
- R9: In slave mode, `ctl_sdo_off`=1 keeps `sdo_en` low all the time, and reception still works.
- R10: When `ctl_en` is low, one clock later `cs_n_o` is high and `sck_o` sits at the polarity level. A frame that was partly shifted is dropped and no word from it is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_frame | input | 16 | Rate[15:8], phase[7], polarity[6], format[5:4]=00, width-1[3:0] |
| ctl_pre | input | 8 | Even prescaler, 2..254 |
| ctl_en | input | 1 | Engine enable; change other controls only while low |
| ctl_slave | input | 1 | 1 selects slave mode |
| ctl_sdo_off | input | 1 | Slave keeps its data output undriven |
| wr_en | input | 1 | Push `wr_data` into the transmit FIFO |
| wr_data | input | 16 | Transmit word |
| tx_not_full | output | 1 | Transmit FIFO has room |
| rd_en | input | 1 | Pop the receive FIFO |
| rd_data | output | 16 | Oldest received word |
| rx_not_empty | output | 1 | Receive FIFO holds data |
| sck_o | output | 1 | Serial clock out (master) |
| sck_i | input | 1 | Serial clock in (slave) |
| cs_n_o | output | 1 | Select out (master), active low |
| cs_n_i | input | 1 | Select in (slave), active low |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Output enable for `sdo` |
| sdi | input | 1 | Serial data in |

## Verification
The bench loops `sdo` back to `sdi` and sends words in every clock mode at several widths. A polarity or phase error, a shift in the wrong order, or a failure to drop the upper bits of a word would show up as a received word that differs from the one sent. It measures the clock period at two divider settings, which catches a prescaler that is not halved or a rate counter that is off by one. It checks that two queued words share one select period, and that a ninth write into a full FIFO never comes out. It drives the slave by hand in two modes and with the output disabled, and it disables the engine in the middle of a frame to confirm that the clock and select return to idle and that no word is received.

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] ctl_frame,
  input  logic [7:0]  ctl_pre,
  input  logic        ctl_en,
  input  logic        ctl_slave,
  input  logic        ctl_sdo_off,
  input  logic        wr_en,
  input  logic [15:0] wr_data,
  output logic        tx_not_full,
  input  logic        rd_en,
  output logic [15:0] rd_data,
  output logic        rx_not_empty,
  output logic        sck_o,
  input  logic        sck_i,
  output logic        cs_n_o,
  input  logic        cs_n_i,
  output logic        sdo,
  output logic        sdo_en,
  input  logic        sdi
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL = (AW+1)'(DEPTH);

  wire [7:0] rate = ctl_frame[15:8];
  wire       cpha = ctl_frame[7];
  wire       cpol = ctl_frame[6];
  wire [3:0] wm1  = ctl_frame[3:0];

  logic [15:0] txm [DEPTH];
  logic [15:0] rxm [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [AW:0]   tx_cnt, rx_cnt;

  logic        active, h, first;
  logic [4:0]  left;
  logic [15:0] tsh, rsh;
  logic [6:0]  pcnt;
  logic [7:0]  scnt;
  logic        s1, s2, s3, c1, c2, d1, d2;

  wire [6:0] pre_half = (ctl_pre[7:1] == 7'd0) ? 7'd1 : ctl_pre[7:1];
  wire pdone = (pcnt == pre_half - 7'd1);
  wire tick  = active && !ctl_slave && pdone && (scnt == rate);
  wire sedge = (s2 != s3);
  wire ev_lead  = active && (ctl_slave ? (sedge && s2 != cpol) : (tick && !h));
  wire ev_trail = active && (ctl_slave ? (sedge && s2 == cpol) : (tick && h));
  wire in_bit = ctl_slave ? d2 : sdi;
  wire sel    = !c2;
  wire done   = ev_trail && (left == 5'd1);
  wire tx_have = (tx_cnt != '0);
  wire start_m = ctl_en && !ctl_slave && tx_have && (!active || done);
  wire start_s = ctl_en && ctl_slave && sel && (!active || done);
  wire load    = start_m || start_s;
  wire tx_pop  = load && tx_have;
  wire tx_push = wr_en && (tx_cnt != FULL);
  wire rx_push = done && (rx_cnt != FULL);
  wire rx_pop  = rd_en && (rx_cnt != '0);
  wire [15:0] load_word = tx_have ? txm[tx_rp] : 16'h0000;
  wire [15:0] rx_word   = cpha ? {rsh[14:0], in_bit} : rsh;

  assign tx_not_full  = (tx_cnt != FULL);
  assign rx_not_empty = (rx_cnt != '0);
  assign rd_data      = rxm[rx_rp];
  assign sck_o  = (active && !ctl_slave) ? (cpol ^ h) : cpol;
  assign cs_n_o = !(active && !ctl_slave);
  assign sdo    = tsh[15];
  assign sdo_en = ctl_en && (ctl_slave ? (active && !ctl_sdo_off) : 1'b1);

  always_ff @(posedge clk) begin
    if (tx_push) txm[tx_wp] <= wr_data;
    if (rx_push) rxm[rx_wp] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      if (tx_push && !tx_pop) tx_cnt <= tx_cnt + 1'b1;
      else if (!tx_push && tx_pop) tx_cnt <= tx_cnt - 1'b1;
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      if (rx_push && !rx_pop) rx_cnt <= rx_cnt + 1'b1;
      else if (!rx_push && rx_pop) rx_cnt <= rx_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      c1 <= 1'b1; c2 <= 1'b1; d1 <= 1'b0; d2 <= 1'b0;
    end else begin
      s1 <= sck_i;  s2 <= s1; s3 <= s2;
      c1 <= cs_n_i; c2 <= c1;
      d1 <= sdi;    d2 <= d1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0; scnt <= '0;
    end else if (!active || load) begin
      pcnt <= '0; scnt <= '0;
    end else if (pdone) begin
      pcnt <= '0;
      scnt <= (scnt == rate) ? 8'd0 : scnt + 8'd1;
    end else begin
      pcnt <= pcnt + 7'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; h <= 1'b0; first <= 1'b0;
      left <= '0; tsh <= '0; rsh <= '0;
    end else if (!ctl_en || (ctl_slave && active && !sel)) begin
      active <= 1'b0; h <= 1'b0;
    end else if (load) begin
      active <= 1'b1; h <= 1'b0; first <= 1'b1;
      left <= {1'b0, wm1} + 5'd1;
      tsh  <= load_word << (4'd15 - wm1);
      rsh  <= '0;
    end else if (done) begin
      active <= 1'b0; h <= 1'b0;
    end else begin
      if (ev_lead) begin
        h <= 1'b1; first <= 1'b0;
        if (!cpha) rsh <= {rsh[14:0], in_bit};
        else if (!first) tsh <= tsh << 1;
      end
      if (ev_trail) begin
        h <= 1'b0;
        left <= left - 5'd1;
        if (cpha) rsh <= {rsh[14:0], in_bit};
        else tsh <= tsh << 1;
      end
    end
  end

  AST_PRESCALE_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_en && !ctl_slave) |-> (!ctl_pre[0] && ctl_pre != 8'd0)); // R1
  AST_FORMAT_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_en |-> (ctl_frame[5:4] == 2'b00)); // R3
  AST_IDLE_CLOCK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> (sck_o == cpol)); // R3
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= FULL); // R6
  AST_TX_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt == FULL && wr_en && !tx_pop) |=> (tx_cnt == FULL && $stable(tx_wp))); // R6
  AST_RX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= FULL); // R7
  AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> cs_n_o); // R10
endmodule

// File: tb/sync_serial_port_test.sv
module sync_serial_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  localparam logic [39:0] VEC [NV] = '{
    {2'd0, 2'd0, 4'd7,  16'h00A5, 16'h00A5},
    {2'd1, 2'd0, 4'd7,  16'h003C, 16'h003C},
    {2'd2, 2'd0, 4'd15, 16'hBEEF, 16'hBEEF},
    {2'd3, 2'd0, 4'd11, 16'hF123, 16'h0123},
    {2'd0, 2'd0, 4'd3,  16'hFFF5, 16'h0005},
    {2'd3, 2'd0, 4'd15, 16'h8001, 16'h8001},
    {2'd2, 2'd0, 4'd4,  16'h0FFF, 16'h001F}
  };

  logic clk = 0, rst_n = 0;
  logic [15:0] ctl_frame = '0;
  logic [7:0] ctl_pre = 8'd2;
  logic ctl_en = 0, ctl_slave = 0, ctl_sdo_off = 0;
  logic wr_en = 0, rd_en = 0;
  logic [15:0] wr_data = '0;
  logic tx_not_full, rx_not_empty, sck_o, cs_n_o, sdo, sdo_en;
  logic [15:0] rd_data;
  logic sck_i = 0, cs_n_i = 1, bb_sdi = 0, loop_on = 1;
  wire sdi = loop_on ? sdo : bb_sdi;
  int checks = 0, errors = 0;
  bit finished = 0;

  sync_serial_port uut (
    .clk(clk), .rst_n(rst_n), .ctl_frame(ctl_frame), .ctl_pre(ctl_pre),
    .ctl_en(ctl_en), .ctl_slave(ctl_slave), .ctl_sdo_off(ctl_sdo_off),
    .wr_en(wr_en), .wr_data(wr_data), .tx_not_full(tx_not_full),
    .rd_en(rd_en), .rd_data(rd_data), .rx_not_empty(rx_not_empty),
    .sck_o(sck_o), .sck_i(sck_i), .cs_n_o(cs_n_o), .cs_n_i(cs_n_i),
    .sdo(sdo), .sdo_en(sdo_en), .sdi(sdi));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setup(input logic [1:0] mode, input logic [3:0] wm1, input logic [7:0] pre,
                       input logic [7:0] rate, input logic slv, input logic off);
    @(negedge clk);
    ctl_en = 0;
    ctl_frame = {rate, mode[0], mode[1], 2'b00, wm1};
    ctl_pre = pre; ctl_slave = slv; ctl_sdo_off = off;
    sck_i = mode[1];
    wait_n(4);
  endtask

  task automatic push(input logic [15:0] w);
    @(negedge clk); wr_en = 1; wr_data = w;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pop_chk(input logic [15:0] exp, input string req);
    for (int i = 0; i < 3000 && !rx_not_empty; i++) @(negedge clk);
    chk(rx_not_empty && rd_data == exp, req, {15'd0, rx_not_empty, rd_data}, {16'd1, exp});
    rd_en = 1; @(negedge clk); rd_en = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && !cs_n_o; i++) @(negedge clk);
    wait_n(2);
  endtask

  task automatic measure(input logic [7:0] pre, input logic [7:0] rate, input int exp);
    int n = 0;
    int seen = 0;
    logic prev;
    setup(2'd0, 4'd7, pre, rate, 0, 0);
    push(16'h00FF);
    @(negedge clk); ctl_en = 1;
    prev = sck_o;
    for (int i = 0; i < 5000 && seen < 2; i++) begin
      @(negedge clk);
      if (seen == 1) n++;
      if (sck_o && !prev) seen++;
      prev = sck_o;
    end
    chk(n == exp, "R1 clock period", n, exp);
    wait_idle();
    pop_chk(16'h00FF, "R1 word");
  endtask

  task automatic slave_xfer(input logic cpol, input logic cpha, input logic [3:0] wm1,
                            input logic [15:0] send, output logic [15:0] got, output bit en_all, output bit en_any);
    got = '0; en_all = 1; en_any = 0;
    @(negedge clk); cs_n_i = 0; sck_i = cpol;
    wait_n(8);
    for (int b = int'(wm1); b >= 0; b--) begin
      if (!cpha) begin
        bb_sdi = send[b]; wait_n(8);
        got = {got[14:0], sdo}; en_all &= sdo_en; en_any |= sdo_en;
        sck_i = !cpol; wait_n(8);
        sck_i = cpol; wait_n(8);
      end else begin
        sck_i = !cpol; bb_sdi = send[b]; wait_n(8);
        got = {got[14:0], sdo}; en_all &= sdo_en; en_any |= sdo_en;
        sck_i = cpol; wait_n(8);
      end
    end
    wait_n(8); cs_n_i = 1; wait_n(8);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] got;
    bit ea, ey;
    int cs_rises, sck_rises;
    logic msb, pc, ps;
    wait_n(3); rst_n = 1; wait_n(2);
    // reset state R6 R7 R5 R8
    chk(tx_not_full == 1, "R6 reset", tx_not_full, 1);
    chk(rx_not_empty == 0, "R7 reset", rx_not_empty, 0);
    chk(cs_n_o == 1, "R5 reset", cs_n_o, 1);
    chk(sdo_en == 0, "R8 reset", sdo_en, 0);

    // R2 R3 loopback table
    for (int v = 0; v < NV; v++) begin
      setup(VEC[v][39:38], VEC[v][35:32], 8'd2, 8'd1, 0, 0);
      chk(sck_o == VEC[v][39], "R3 idle level", sck_o, VEC[v][39]);
      push(VEC[v][31:16]);
      @(negedge clk); ctl_en = 1;
      pop_chk(VEC[v][15:0], "R2/R3 loopback");
      wait_idle();
    end

    // R1 divider
    measure(8'd4, 8'd2, 12);
    measure(8'd2, 8'd0, 2);

    // R5 R4 back-to-back frames
    setup(2'd0, 4'd7, 8'd2, 8'd3, 0, 0);
    push(16'h0082); push(16'h007E);
    @(negedge clk); ctl_en = 1;
    cs_rises = 0; sck_rises = 0; msb = 0; pc = cs_n_o; ps = sck_o;
    for (int i = 0; i < 3000 && cs_rises == 0; i++) begin
      @(negedge clk);
      if (!cs_n_o && sck_o && !ps) begin
        if (sck_rises == 0) msb = sdo;
        sck_rises++;
      end
      if (cs_n_o && !pc) cs_rises++;
      pc = cs_n_o; ps = sck_o;
    end
    chk(sck_rises == 16, "R5 one select for two frames", sck_rises, 16);
    chk(msb == 1'b1, "R4 msb first", msb, 1);
    pop_chk(16'h0082, "R4 first word");
    pop_chk(16'h007E, "R5 second word");

    // R6 FIFO depth and dropped write
    setup(2'd0, 4'd7, 8'd2, 8'd0, 0, 0);
    for (int k = 1; k <= 7; k++) push(16'(k));
    chk(tx_not_full == 1, "R6 seven words", tx_not_full, 1);
    push(16'd8);
    chk(tx_not_full == 0, "R6 full", tx_not_full, 0);
    push(16'd9);
    @(negedge clk); ctl_en = 1;
    wait_n(400);
    for (int k = 1; k <= 8; k++) pop_chk(16'(k), "R7 order");
    chk(rx_not_empty == 0, "R6 dropped write", rx_not_empty, 0);

    // R10 disable mid-frame
    setup(2'd2, 4'd15, 8'd8, 8'd10, 0, 0);
    push(16'hAAAA);
    @(negedge clk); ctl_en = 1;
    wait_n(60);
    chk(cs_n_o == 0, "R10 running", cs_n_o, 0);
    ctl_en = 0;
    wait_n(2);
    chk(cs_n_o == 1 && sck_o == 1, "R10 idle", {cs_n_o, sck_o}, 2'b11);
    wait_n(2000);
    chk(rx_not_empty == 0, "R10 no word", rx_not_empty, 0);

    // R8 slave mode 0 and mode 3
    loop_on = 0;
    setup(2'd0, 4'd7, 8'd2, 8'd0, 1, 0);
    push(16'h0096);
    @(negedge clk); ctl_en = 1;
    slave_xfer(0, 0, 4'd7, 16'h005A, got, ea, ey);
    chk(got == 16'h0096, "R8 slave tx mode0", got, 16'h0096);
    chk(ea == 1, "R8 sdo_en while selected", ea, 1);
    chk(sdo_en == 0, "R8 sdo_en released", sdo_en, 0);
    pop_chk(16'h005A, "R8 slave rx mode0");

    setup(2'd3, 4'd11, 8'd2, 8'd0, 1, 0);
    push(16'hFABC);
    @(negedge clk); ctl_en = 1;
    slave_xfer(1, 1, 4'd11, 16'h0365, got, ea, ey);
    chk(got == 16'h0ABC, "R8 slave tx mode3", got, 16'h0ABC);
    pop_chk(16'h0365, "R8 slave rx mode3");

    // R9 output disabled slave
    setup(2'd0, 4'd7, 8'd2, 8'd0, 1, 1);
    push(16'h00C3);
    @(negedge clk); ctl_en = 1;
    slave_xfer(0, 0, 4'd7, 16'h003C, got, ea, ey);
    chk(ey == 0 && sdo_en == 0, "R9 sdo_en held low", {ey, sdo_en}, 0);
    pop_chk(16'h003C, "R9 rx still works");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule